// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port with a bank of pins (twelve by default) controlled through a small 32-bit register bus. Each pin can be an output, driven from a data register, or an input whose level is resynchronised into the clock domain and can be read back. Every input can also raise an interrupt. Its trigger condition is chosen per pin from five kinds: a rising edge, a falling edge, either edge, a high level or a low level.

A detected event latches a per-pin status bit, but only while that pin's enable bit is set. Software clears status by writing ones. A separate mask hides latched status from the interrupt line without discarding it. The mask is changed only through a write-one-to-set word and a write-one-to-clear word, so a single pin can be masked or unmasked without a read-modify-write. A display word shows the status bits that are not masked, and the single interrupt output is high whenever any of them is set. A software reset word returns every control register to zero.

The bus uses word addresses. A write takes effect on the clock edge that samples `bus_wr`. Read data is combinational from the current address. The parameter `NPINS` may be set from 1 to 16.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After the hard reset (`rst_n` low), every one of the 16 word addresses reads zero while all pins are low, and `irq`, `pin_oe` and `pin_out` are zero.
- R2: `pin_oe` equals the direction word (address 8; a 1 selects output) and `pin_out` equals the output-data word (address 6), both taken from the low `NPINS` bits written.
- R3: The input word (address 7) returns the pin levels delayed by two clock edges. A change on `pin_in` is visible after the second rising edge and not after the first.
- R4: The mode of pin i is the 3-bit code in bits [4k+2:4k] of mode word 0 (address 9) for i < 8 with k = i, and of mode word 1 (address 10) for i >= 8 with k = i-8. Codes: 000 falling edge, 001 rising edge, 010 low level, 011 high level, and any code with bit 2 set means both edges. Mode words read back the stored codes, with bit 4k+3 reading 0.
- R5: A status bit (address 1) is set by its pin's trigger condition only while the pin's enable bit (address 0) is 1. An edge is seen three rising edges after the pin changes. A level is judged on the synchronised value in every cycle.
- R6: Writing a 1 in bit i of address 4 masks pin i. Writing a 1 in bit i of address 5 unmasks it. Zero bits change nothing. The mask reads back at address 4.
- R7: Writing a 1 in bit i of address 3 clears status bit i, and zero bits leave status unchanged. In a level mode the bit is set again while the level holds, so clearing succeeds only after the level is left.
- R8: When a trigger event and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R9: The display word (address 2) reads status AND NOT mask, and `irq` is high exactly when the display word is nonzero.
- R10: Writing 1 to bit 0 of the reset word (address 15) forces every control register, including status, to zero. Writes to other words are ignored while the bit stays 1, and the word reads back 1. After 0 is written, all words read zero again.
- R11: Addresses 11, 12 and 13 read zero and ignore writes. Bits at or above `NPINS` of the per-pin words read zero. Address 14 is a plain read/write per-pin word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output data to the pads |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can land on one status bit in the same cycle: a detected trigger that sets the bit, and a software write that clears it. The bench times a clear write to be sampled on exactly the edge where a rising-edge event on a pin is latched, and expects the bit to read 1 afterwards. It then issues the same clear one cycle later and expects 0. It also holds a pin at an active level while clearing, which makes the two collide every cycle, and expects the clear to fail until the level is released.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_AW = 4;

    // word addresses
    localparam logic [REG_AW-1:0] A_EN    = 4'd0;
    localparam logic [REG_AW-1:0] A_STAT  = 4'd1;
    localparam logic [REG_AW-1:0] A_DISP  = 4'd2;
    localparam logic [REG_AW-1:0] A_CLR   = 4'd3;
    localparam logic [REG_AW-1:0] A_MSET  = 4'd4;
    localparam logic [REG_AW-1:0] A_MCLR  = 4'd5;
    localparam logic [REG_AW-1:0] A_POUT  = 4'd6;
    localparam logic [REG_AW-1:0] A_PIN   = 4'd7;
    localparam logic [REG_AW-1:0] A_DIR   = 4'd8;
    localparam logic [REG_AW-1:0] A_MODE0 = 4'd9;
    localparam logic [REG_AW-1:0] A_MODE1 = 4'd10;
    localparam logic [REG_AW-1:0] A_FSEL  = 4'd14;
    localparam logic [REG_AW-1:0] A_SRST  = 4'd15;

    localparam int unsigned MODE_W      = 3;
    localparam int unsigned NIB_W       = 4;
    localparam int unsigned PINS_PER_WD = 8;

    // trigger decision for one pin from its mode code
    function automatic logic trig_hit(input logic [MODE_W-1:0] m,
                                      input logic cur, input logic prv);
        logic r;
        if (m[2]) begin
            r = cur ^ prv;
        end else begin
            case (m[1:0])
                2'b00:   r = prv & ~cur;
                2'b01:   r = ~prv & cur;
                2'b10:   r = ~cur;
                default: r = cur;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W      = 12,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], d};
    end

    assign q      = pipe_q[STAGES-1];
    assign q_prev = pipe_q[STAGES];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0][MODE_W-1:0] mode,
    input  logic [W-1:0]             cur,
    input  logic [W-1:0]             prv,
    output logic [W-1:0]             hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = trig_hit(mode[i], cur[i], prv[i]);
    end
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [REG_AW-1:0]        addr,
    input  logic [W-1:0]             en,
    input  logic [W-1:0]             status,
    input  logic [W-1:0]             mask,
    input  logic [W-1:0]             pout,
    input  logic [W-1:0]             pin_s,
    input  logic [W-1:0]             dir,
    input  logic [W-1:0]             fsel,
    input  logic [W-1:0][MODE_W-1:0] mode,
    input  logic                     srst,
    output logic [31:0]              rdata
);
    logic [31:0] mode0_w, mode1_w;

    always_comb begin
        mode0_w = '0;
        mode1_w = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (i < int'(PINS_PER_WD))
                mode0_w[NIB_W*(i%PINS_PER_WD) +: MODE_W] = mode[i];
            else
                mode1_w[NIB_W*(i%PINS_PER_WD) +: MODE_W] = mode[i];
        end
    end

    always_comb begin
        case (addr)
            A_EN:    rdata = 32'(en);
            A_STAT:  rdata = 32'(status);
            A_DISP:  rdata = 32'(status & ~mask);
            A_MSET:  rdata = 32'(mask);
            A_POUT:  rdata = 32'(pout);
            A_PIN:   rdata = 32'(pin_s);
            A_DIR:   rdata = 32'(dir);
            A_MODE0: rdata = mode0_w;
            A_MODE1: rdata = mode1_w;
            A_FSEL:  rdata = 32'(fsel);
            A_SRST:  rdata = 32'(srst);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS   = 12,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    typedef struct packed {
        logic [NPINS-1:0]             en;
        logic [NPINS-1:0]             status;
        logic [NPINS-1:0]             mask;
        logic [NPINS-1:0]             pout;
        logic [NPINS-1:0]             dir;
        logic [NPINS-1:0]             fsel;
        logic [NPINS-1:0][MODE_W-1:0] mode;
        logic                         srst;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NPINS-1:0] sync_w, prev_w, hit_w, wlo;
    logic             unused_wdata;

    assign wlo          = bus_wdata[NPINS-1:0];
    assign unused_wdata = ^bus_wdata;

    gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_ST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (sync_w),
        .q_prev (prev_w)
    );

    gpio_irq_detect #(.W(NPINS)) u_detect (
        .mode (regs_q.mode),
        .cur  (sync_w),
        .prv  (prev_w),
        .hit  (hit_w)
    );

    gpio_irq_rdmux #(.W(NPINS)) u_rdmux (
        .addr   (bus_addr),
        .en     (regs_q.en),
        .status (regs_q.status),
        .mask   (regs_q.mask),
        .pout   (regs_q.pout),
        .pin_s  (sync_w),
        .dir    (regs_q.dir),
        .fsel   (regs_q.fsel),
        .mode   (regs_q.mode),
        .srst   (regs_q.srst),
        .rdata  (bus_rdata)
    );

    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                A_EN:   regs_d.en     = wlo;
                A_CLR:  regs_d.status = regs_q.status & ~wlo;
                A_MSET: regs_d.mask   = regs_q.mask | wlo;
                A_MCLR: regs_d.mask   = regs_q.mask & ~wlo;
                A_POUT: regs_d.pout   = wlo;
                A_DIR:  regs_d.dir    = wlo;
                A_FSEL: regs_d.fsel   = wlo;
                A_SRST: regs_d.srst   = bus_wdata[0];
                A_MODE0: begin
                    for (int i = 0; i < int'(NPINS); i++)
                        if (i < int'(PINS_PER_WD))
                            regs_d.mode[i] = bus_wdata[NIB_W*(i%PINS_PER_WD) +: MODE_W];
                end
                A_MODE1: begin
                    for (int i = 0; i < int'(NPINS); i++)
                        if (i >= int'(PINS_PER_WD))
                            regs_d.mode[i] = bus_wdata[NIB_W*(i%PINS_PER_WD) +: MODE_W];
                end
                default: ;
            endcase
        end
        // detected events are applied after the clear, so they win
        regs_d.status = regs_d.status | (hit_w & regs_q.en);
        // while soft reset is held, only the reset word itself accepts writes
        if (regs_q.srst) begin
            regs_d      = '0;
            regs_d.srst = (bus_wr && bus_addr == A_SRST) ? bus_wdata[0] : 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pin_out = regs_q.pout;
    assign pin_oe  = regs_q.dir;
    assign irq     = |(regs_q.status & ~regs_q.mask);

    // plain views of internal state for the bound checker
    logic [NPINS-1:0] chk_status, chk_en, chk_mask;
    logic             chk_srst;
    assign chk_status = regs_q.status;
    assign chk_en     = regs_q.en;
    assign chk_mask   = regs_q.mask;
    assign chk_srst   = regs_q.srst;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int unsigned NPINS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] sync_w,
    input logic             bus_wr,
    input logic [NPINS-1:0] status,
    input logic [NPINS-1:0] en,
    input logic [NPINS-1:0] mask,
    input logic             srst,
    input logic             irq
);
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (sync_w == $past(pin_in, 2)));

    // R5
    set_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> ((status & ~$past(status) & ~$past(en)) == '0));

    // R9
    irq_has_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

    // R9
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);

    // R10
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (status == '0 && mask == '0 && en == '0));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !srst) |=> $stable(mask));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .sync_w (sync_w),
    .bus_wr (bus_wr),
    .status (chk_status),
    .en     (chk_en),
    .mask   (chk_mask),
    .srst   (chk_srst),
    .irq    (irq)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
    localparam int N = 12;
    localparam logic [N-1:0] ALL = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_ctrl #(.NPINS(N)) u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_hit(input logic [2:0] m, input logic v0, input logic v1);
        if (m[2]) return v0 ^ v1;
        case (m[1:0])
            2'b00:   return v0 & ~v1;
            2'b01:   return ~v0 & v1;
            2'b10:   return ~v0 | ~v1;
            default: return v0 | v1;
        endcase
    endfunction

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd4242));
        waitn(4);
        rst_n = 1'b1;
        waitn(1);

        // R1 reset state
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], r);
            check($sformatf("R1 word %0d", a), r, 32'h0);
        end
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pin_oe", 32'(pin_oe), 32'h0);

        // R2 direction and output data
        wr(4'd8, 32'h0000_0A5A);
        wr(4'd6, 32'hFFFF_F0F3);
        check("R2 pin_oe", 32'(pin_oe), 32'h0000_0A5A);
        check("R2 pin_out", 32'(pin_out), 32'h0000_00F3);
        rd(4'd6, r);
        check("R11 out word upper bits", r, 32'h0000_00F3);

        // R3 input sampling latency
        @(negedge clk);
        pin_in = 12'h5C3;
        @(negedge clk);
        rd(4'd7, r);
        check("R3 after one edge", r, 32'h0);
        @(negedge clk);
        rd(4'd7, r);
        check("R3 after two edges", r, 32'h0000_05C3);
        pin_in = '0;
        waitn(4);

        // R11 reserved words and function select
        wr(4'd12, 32'hFFFF_FFFF);
        wr(4'd11, 32'hFFFF_FFFF);
        for (int a = 11; a < 14; a++) begin
            rd(a[3:0], r);
            check($sformatf("R11 reserved %0d", a), r, 32'h0);
        end
        wr(4'd14, 32'hFFFF_F123);
        rd(4'd14, r);
        check("R11 fsel", r, 32'h0000_0123);

        // R6 mask set / clear
        wr(4'd4, 32'h00F);
        wr(4'd4, 32'h300);
        rd(4'd4, r);
        check("R6 mask set", r, 32'h30F);
        wr(4'd4, 32'h0);
        rd(4'd4, r);
        check("R6 set zeros", r, 32'h30F);
        wr(4'd5, 32'h001);
        rd(4'd5, r);
        rd(4'd4, r);
        check("R6 mask clear", r, 32'h30E);
        wr(4'd5, 32'h0);
        rd(4'd4, r);
        check("R6 clear zeros", r, 32'h30E);
        wr(4'd5, 32'hFFF);

        // R4 mode readback
        wr(4'd9, 32'hFFFF_FFFF);
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd9, r);
        check("R4 mode0 readback", r, 32'h7777_7777);
        rd(4'd10, r);
        check("R4 mode1 readback", r, 32'h0000_7777);

        // R5 enable gate: rising edge with enable off
        wr(4'd9, 32'h1111_1111);
        wr(4'd10, 32'h0000_1111);
        wr(4'd0, 32'h0);
        @(negedge clk);
        pin_in = ALL;
        waitn(4);
        rd(4'd1, r);
        check("R5 no set while disabled", r, 32'h0);
        pin_in = '0;
        waitn(4);

        // R4 R5 R9 random modes, enables, masks, pin transitions
        for (int it = 0; it < 40; it++) begin
            logic [N-1:0] v0, v1, en, mk, es;
            logic [2:0]   md [N];
            logic [31:0]  m0, m1;
            v0 = N'($urandom); v1 = N'($urandom);
            en = N'($urandom); mk = N'($urandom);
            m0 = '0; m1 = '0;
            for (int i = 0; i < N; i++) begin
                md[i] = 3'($urandom);
                if (i < 8) m0[4*i +: 3] = md[i];
                else       m1[4*(i-8) +: 3] = md[i];
            end
            wr(4'd0, 32'h0);
            @(negedge clk);
            pin_in = v0;
            waitn(4);
            wr(4'd3, 32'hFFFF_FFFF);
            wr(4'd9, m0);
            wr(4'd10, m1);
            wr(4'd5, 32'hFFFF_FFFF);
            wr(4'd4, 32'(mk));
            wr(4'd0, 32'(en));
            pin_in = v1;
            waitn(4);
            es = '0;
            for (int i = 0; i < N; i++) es[i] = en[i] & exp_hit(md[i], v0[i], v1[i]);
            rd(4'd1, r);
            check($sformatf("R4 R5 status it%0d", it), r, 32'(es));
            rd(4'd2, r);
            check($sformatf("R9 display it%0d", it), r, 32'(es & ~mk));
            check($sformatf("R9 irq it%0d", it), {31'b0, irq}, {31'b0, |(es & ~mk)});
        end
        wr(4'd0, 32'h0);
        @(negedge clk);
        pin_in = '0;
        waitn(4);
        wr(4'd3, 32'hFFFF_FFFF);
        wr(4'd5, 32'hFFFF_FFFF);

        // R7 level mode: clear fails while level holds
        wr(4'd9, 32'h0000_3000);   // pin 3 high level
        wr(4'd10, 32'h0000_0010);  // pin 9 rising edge
        wr(4'd0, 32'h208);
        @(negedge clk);
        pin_in = 12'h008;
        waitn(4);
        wr(4'd3, 32'h008);
        rd(4'd1, r);
        check("R7 level clear while held", r, 32'h008);
        pin_in = '0;
        waitn(4);
        wr(4'd3, 32'h008);
        rd(4'd1, r);
        check("R7 level clear after release", r, 32'h0);

        // R7 edge status: zero write keeps, one write clears
        @(negedge clk);
        pin_in = 12'h200;
        waitn(4);
        wr(4'd3, 32'h0);
        rd(4'd1, r);
        check("R7 clear with zeros", r, 32'h200);
        wr(4'd3, 32'h200);
        rd(4'd1, r);
        check("R7 edge clear", r, 32'h0);
        pin_in = '0;
        waitn(4);
        wr(4'd3, 32'hFFF);

        // R8 set and clear collide
        @(negedge clk);
        pin_in = 12'h200;
        @(negedge clk);
        wr(4'd3, 32'h200);         // sampled on the latching edge
        rd(4'd1, r);
        check("R8 set wins over clear", r, 32'h200);
        check("R9 irq after collision", {31'b0, irq}, 32'h1);
        wr(4'd3, 32'h200);
        rd(4'd1, r);
        check("R8 later clear succeeds", r, 32'h0);

        // R10 soft reset
        wr(4'd0, 32'hABC);
        wr(4'd4, 32'h123);
        wr(4'd8, 32'hF0F);
        wr(4'd6, 32'h0FF);
        wr(4'd14, 32'h055);
        wr(4'd9, 32'h1234_5670);
        wr(4'd15, 32'h1);
        rd(4'd15, r);
        check("R10 reset word reads 1", r, 32'h1);
        wr(4'd0, 32'hFFF);
        rd(4'd0, r);
        check("R10 write ignored while held", r, 32'h0);
        wr(4'd15, 32'h0);
        pin_in = '0;
        waitn(3);
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], r);
            check($sformatf("R10 word %0d after soft reset", a), r, 32'h0);
        end
        check("R10 pin_oe", 32'(pin_oe), 32'h0);
        check("R10 irq", {31'b0, irq}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule